// File: doc/BRIEF.md
# Mode-Selectable Serial Channel Byte FIFOs

This block holds the byte storage for one serial channel. On the receive side, characters arrive one byte at a time from the deserializer. A packer either gathers them into 32-bit little-endian words or passes each one straight through. The result goes into a receive FIFO, which presents entries to a buffer-write consumer as a data word plus a count of valid bytes. On the transmit side, a byte FIFO sits between a push interface fed from memory and a pop interface drained by the serializer.

Two configuration bits set the geometry. The receive bit picks between wide storage and narrow storage. Wide storage holds 8 word entries (32 bytes) and normally delivers only complete words. Narrow storage holds 8 single-byte entries and delivers each character on arrival. The transmit bit picks between a 32-byte FIFO and a single-byte FIFO for minimum latency. The configuration bits are taken only while the channel enable is low, and taking a new value empties both FIFOs. In wide mode, a flush input pushes out a partly gathered word.

Top module: `ser_chan_fifos`

## Requirements
- R1: With `cfg_tx_lowlat`=0, the transmit FIFO accepts 32 bytes. `tx_push_ready` is high while fewer than 32 bytes are held, and a push made while it is low is discarded. Bytes are popped in push order, and `tx_pop_data` shows the oldest byte whenever `tx_pop_valid` is high.
- R2: With `cfg_tx_lowlat`=1, the transmit FIFO holds one byte. `tx_push_ready` falls as soon as one byte is stored.
- R3: With `cfg_rx_narrow`=0, received bytes are packed little-endian: the first byte of a word goes in bits 7:0 and the fourth in bits 31:24. A word is offered on `buf_valid` only after its fourth byte, with `buf_count`=4. The receive FIFO holds 8 such words.
- R4: With `cfg_rx_narrow`=1, each received byte is offered as its own entry on the cycle after it arrives. The byte is in bits 7:0, bits 31:8 are zero and `buf_count`=1. The receive FIFO holds 8 entries.
- R5: In wide mode, `rx_flush` pushes a partly gathered word of 1 to 3 bytes, with `buf_count` equal to the byte count and unused lanes zero. A flush has no effect when no bytes are pending, when the receive FIFO is full, or in narrow mode.
- R6: When `rx_valid` and `rx_flush` are high in the same cycle in wide mode, the new byte is appended first, and the flushed word includes it.
- R7: A byte that cannot be stored is dropped, and `rx_overrun` is set. In narrow mode this happens when the receive FIFO is full. In wide mode it happens when the receive FIFO is full and three bytes are already pending. `rx_overrun` stays set while `chan_en` is high and clears on any cycle with `chan_en` low.
- R8: Configuration bits are taken only while `chan_en` is low. A change made while `chan_en` is high has no effect on capacity or packing.
- R9: When a new configuration value is taken, both FIFOs and the packer are emptied in the same cycle.
- R10: After reset, both FIFOs are empty, the mode is wide receive with the 32-byte transmit FIFO, and `rx_overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; configuration is taken only while low |
| cfg_tx_lowlat | input | 1 | 1 selects the one-byte transmit FIFO |
| cfg_rx_narrow | input | 1 | 1 selects per-byte receive delivery |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_flush | input | 1 | Push the partial word out (wide mode) |
| buf_valid | output | 1 | Receive FIFO entry available |
| buf_data | output | 32 | Receive entry data, first byte in bits 7:0 |
| buf_count | output | 3 | Valid bytes in the entry, 1 to 4 |
| buf_ready | input | 1 | Consumer takes the entry |
| rx_overrun | output | 1 | Sticky flag for a dropped byte |
| tx_push_valid | input | 1 | Transmit byte offered |
| tx_push_data | input | 8 | Transmit byte |
| tx_push_ready | output | 1 | Transmit FIFO has space |
| tx_pop | input | 1 | Serializer takes the oldest byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| tx_pop_valid | output | 1 | Transmit FIFO not empty |

## Verification
In wide mode, the arrival of a byte and a flush request can land in the same cycle. The bench raises `rx_valid` and `rx_flush` together with two bytes pending, and again with none pending. It then checks that the single delivered word carries the new byte in the right lane and has a count of three or one. A second collision happens when the fourth byte arrives while the receive FIFO is full: the bench fills all eight entries with the consumer stalled. It then checks that bytes which still fit in the packer are kept and that only the completing byte is lost. This is judged by the flag and by the word that a later flush pushes out.

// File: rtl/ser_chan_fifos_pkg.sv
package ser_chan_fifos_pkg;

  typedef struct packed {
    logic tx_lowlat;
    logic rx_narrow;
  } scf_mode_t;

endpackage

// File: rtl/scf_fifo.sv
module scf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CW-1:0]    cap,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0]    count, count_n;
  logic             do_wr, do_rd;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (do_wr) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
    if (do_rd) rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    if (do_wr && !do_rd)      count_n = count + CW'(1);
    else if (!do_wr && do_rd) count_n = count - CW'(1);
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  // R1 R2: occupancy never goes past the capacity chosen by the mode
  a_r1_r2_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);

  // R9: a clear leaves the FIFO empty on the next cycle
  a_r9_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/scf_mode_ctl.sv
module scf_mode_ctl
  import ser_chan_fifos_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chan_en,
  input  scf_mode_t cfg,
  output scf_mode_t mode,
  output logic      clr
);

  scf_mode_t mode_n;

  assign clr = !chan_en && (cfg != mode);

  always_comb begin
    mode_n = mode;
    if (clr) mode_n = cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else        mode <= mode_n;
  end

  // R8: while the channel runs, the active mode does not move
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(mode));

endmodule

// File: rtl/scf_rx_packer.sv
module scf_rx_packer #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int CW        = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              chan_en,
  input  logic              narrow,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_flush,
  input  logic              fifo_full,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic [CW-1:0]     push_cnt,
  output logic              overrun
);

  logic [WORD_W-1:0] acc, acc_n, base, merged;
  logic [CW-1:0]     fill, fill_n;
  logic              last, drop, overrun_n;

  assign last = (fill == CW'(WORD_BYTES - 1));
  assign base = (fill == '0) ? '0 : acc;

  always_comb begin
    merged = base;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (fill == CW'(i)) merged[i*BYTE_W +: BYTE_W] = rx_byte;
    end
  end

  always_comb begin
    push      = 1'b0;
    push_data = merged;
    push_cnt  = fill + CW'(1);
    acc_n     = acc;
    fill_n    = fill;
    drop      = 1'b0;
    if (narrow) begin
      push_data = WORD_W'(rx_byte);
      push_cnt  = CW'(1);
      if (rx_valid) begin
        if (fifo_full) drop = 1'b1;
        else           push = 1'b1;
      end
    end else if (rx_valid) begin
      if ((last || rx_flush) && !fifo_full) begin
        push   = 1'b1;
        fill_n = '0;
      end else if (last) begin
        drop = 1'b1;
      end else begin
        acc_n  = merged;
        fill_n = fill + CW'(1);
      end
    end else if (rx_flush && (fill != '0) && !fifo_full) begin
      push      = 1'b1;
      push_data = acc;
      push_cnt  = fill;
      fill_n    = '0;
    end
    if (clr) begin
      push   = 1'b0;
      drop   = 1'b0;
      fill_n = '0;
    end
    overrun_n = chan_en ? (overrun || drop) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      acc     <= acc_n;
      fill    <= fill_n;
      overrun <= overrun_n;
    end
  end

  // R3: the gather register never holds a complete word
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill < CW'(WORD_BYTES));

  // R4: narrow pushes carry one byte in lane 0
  a_r4_narrow_single: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && push) |-> (push_cnt == CW'(1) && push_data[WORD_W-1:BYTE_W] == '0));

  // R7: the overrun flag is sticky while enabled
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && chan_en) |=> overrun);

  // R7: a byte refused in narrow mode raises the flag
  a_r7_narrow_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && narrow && rx_valid && fifo_full && !clr) |=> overrun);

endmodule

// File: rtl/ser_chan_fifos.sv
module ser_chan_fifos
  import ser_chan_fifos_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int WORD_BYTES     = 4,
  parameter int TX_DEPTH       = 32,
  parameter int TX_LL_DEPTH    = 1,
  parameter int RX_WIDE_BYTES  = 32,
  parameter int RX_NARROW_BYTES = 8,
  localparam int WORD_W        = BYTE_W * WORD_BYTES,
  localparam int CNT_W         = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cfg_tx_lowlat,
  input  logic              cfg_rx_narrow,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_flush,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_data,
  output logic [CNT_W-1:0]  buf_count,
  input  logic              buf_ready,
  output logic              rx_overrun,
  input  logic              tx_push_valid,
  input  logic [BYTE_W-1:0] tx_push_data,
  output logic              tx_push_ready,
  input  logic              tx_pop,
  output logic [BYTE_W-1:0] tx_pop_data,
  output logic              tx_pop_valid
);

  localparam int RX_ENTRIES = RX_WIDE_BYTES / WORD_BYTES;
  localparam int RX_DEPTH   = (RX_ENTRIES > RX_NARROW_BYTES) ? RX_ENTRIES : RX_NARROW_BYTES;
  localparam int RX_CW      = $clog2(RX_DEPTH + 1);
  localparam int TX_CW      = $clog2(TX_DEPTH + 1);
  localparam int RX_EW      = WORD_W + CNT_W;

  scf_mode_t          cfg, mode;
  logic               clr;
  logic [TX_CW-1:0]   tx_cap;
  logic [RX_CW-1:0]   rx_cap;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic               pk_push;
  logic [WORD_W-1:0]  pk_data;
  logic [CNT_W-1:0]   pk_cnt;
  logic [RX_EW-1:0]   rx_rd;

  assign cfg.tx_lowlat = cfg_tx_lowlat;
  assign cfg.rx_narrow = cfg_rx_narrow;

  scf_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .cfg     (cfg),
    .mode    (mode),
    .clr     (clr)
  );

  assign tx_cap = mode.tx_lowlat ? TX_CW'(TX_LL_DEPTH) : TX_CW'(TX_DEPTH);
  assign rx_cap = mode.rx_narrow ? RX_CW'(RX_NARROW_BYTES) : RX_CW'(RX_ENTRIES);

  scf_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cap     (tx_cap),
    .wr_en   (tx_push_valid),
    .wr_data (tx_push_data),
    .full    (tx_full),
    .rd_en   (tx_pop),
    .rd_data (tx_pop_data),
    .empty   (tx_empty)
  );

  assign tx_push_ready = !tx_full;
  assign tx_pop_valid  = !tx_empty;

  scf_rx_packer #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .chan_en   (chan_en),
    .narrow    (mode.rx_narrow),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_flush  (rx_flush),
    .fifo_full (rx_full),
    .push      (pk_push),
    .push_data (pk_data),
    .push_cnt  (pk_cnt),
    .overrun   (rx_overrun)
  );

  scf_fifo #(.WIDTH(RX_EW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cap     (rx_cap),
    .wr_en   (pk_push),
    .wr_data ({pk_cnt, pk_data}),
    .full    (rx_full),
    .rd_en   (buf_ready),
    .rd_data (rx_rd),
    .empty   (rx_empty)
  );

  assign buf_valid = !rx_empty;
  assign buf_data  = rx_rd[WORD_W-1:0];
  assign buf_count = rx_rd[WORD_W +: CNT_W];

  // R3 R5: every delivered entry carries one to four bytes
  a_r3_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_count != '0 && buf_count <= CNT_W'(WORD_BYTES)));

  // R2: in low-latency transmit mode one stored byte closes the FIFO
  a_r2_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.tx_lowlat && tx_pop_valid) |-> !tx_push_ready);

  // R9: a taken configuration leaves both sides empty
  a_r9_both_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!buf_valid && !tx_pop_valid));

endmodule

// File: tb/ser_chan_fifos_tb_top.sv
module ser_chan_fifos_tb_top;

  logic        clk, rst_n, chan_en, cfg_tx_lowlat, cfg_rx_narrow;
  logic        rx_valid, rx_flush, buf_valid, buf_ready, rx_overrun;
  logic [7:0]  rx_byte, tx_push_data, tx_pop_data;
  logic [31:0] buf_data;
  logic [2:0]  buf_count;
  logic        tx_push_valid, tx_push_ready, tx_pop, tx_pop_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ser_chan_fifos dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .cfg_tx_lowlat(cfg_tx_lowlat), .cfg_rx_narrow(cfg_rx_narrow),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_flush(rx_flush),
    .buf_valid(buf_valid), .buf_data(buf_data), .buf_count(buf_count),
    .buf_ready(buf_ready), .rx_overrun(rx_overrun),
    .tx_push_valid(tx_push_valid), .tx_push_data(tx_push_data),
    .tx_push_ready(tx_push_ready), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_pop_valid(tx_pop_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tx_push(input logic [7:0] b);
    tx_push_valid = 1'b1; tx_push_data = b; tick(); tx_push_valid = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string req);
    chk(tx_pop_valid === 1'b1, req, tx_pop_valid, 1);
    chk(tx_pop_data === exp, req, tx_pop_data, exp);
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic fl);
    rx_valid = 1'b1; rx_byte = b; rx_flush = fl; tick();
    rx_valid = 1'b0; rx_flush = 1'b0;
  endtask

  task automatic flush_only();
    rx_flush = 1'b1; tick(); rx_flush = 1'b0;
  endtask

  task automatic drain(input logic [31:0] exp_d, input logic [2:0] exp_c, input string req);
    chk(buf_valid === 1'b1, req, buf_valid, 1);
    chk(buf_data === exp_d, req, buf_data, exp_d);
    chk(buf_count === exp_c, req, buf_count, exp_c);
    buf_ready = 1'b1; tick(); buf_ready = 1'b0;
  endtask

  task automatic set_cfg(input logic ll, input logic nar);
    chan_en = 1'b0; cfg_tx_lowlat = ll; cfg_rx_narrow = nar; tick();
    chan_en = 1'b1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; cfg_tx_lowlat = 1'b0; cfg_rx_narrow = 1'b0;
    rx_valid = 1'b0; rx_byte = '0; rx_flush = 1'b0; buf_ready = 1'b0;
    tx_push_valid = 1'b0; tx_push_data = '0; tx_pop = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1; tick();

    // R10: reset state
    chk(buf_valid === 1'b0, "R10", buf_valid, 0);
    chk(tx_pop_valid === 1'b0, "R10", tx_pop_valid, 0);
    chk(tx_push_ready === 1'b1, "R10", tx_push_ready, 1);
    chk(rx_overrun === 1'b0, "R10", rx_overrun, 0);
    chan_en = 1'b1; tick();

    // R1: fill the 32-byte transmit FIFO, refuse one more, drain in order
    for (int i = 0; i < 32; i++) begin
      chk(tx_push_ready === 1'b1, "R1", tx_push_ready, 1);
      tx_push(8'(i * 7 + 3));
    end
    chk(tx_push_ready === 1'b0, "R1", tx_push_ready, 0);
    tx_push(8'hEE);
    for (int i = 0; i < 32; i++) tx_take(8'(i * 7 + 3), "R1");
    chk(tx_pop_valid === 1'b0, "R1", tx_pop_valid, 0);

    // R8: switching to low latency while enabled keeps 32-byte capacity
    cfg_tx_lowlat = 1'b1; tick();
    for (int i = 0; i < 5; i++) begin
      chk(tx_push_ready === 1'b1, "R8", tx_push_ready, 1);
      tx_push(8'(8'h40 + i));
    end
    chk(tx_pop_valid === 1'b1, "R8", tx_pop_valid, 1);
    // R9: disabling takes the new value and empties the transmit FIFO
    chan_en = 1'b0; tick();
    chk(tx_pop_valid === 1'b0, "R9", tx_pop_valid, 0);
    chan_en = 1'b1; tick();

    // R2: one-byte transmit FIFO
    chk(tx_push_ready === 1'b1, "R2", tx_push_ready, 1);
    tx_push(8'h5A);
    chk(tx_push_ready === 1'b0, "R2", tx_push_ready, 0);
    tx_push(8'h11);
    tx_take(8'h5A, "R2");
    chk(tx_pop_valid === 1'b0, "R2", tx_pop_valid, 0);
    set_cfg(1'b0, 1'b0);

    // R3 R7: 36 bytes into wide storage with the consumer stalled
    for (int i = 0; i < 36; i++) begin
      rx_send(8'(i + 16), 1'b0);
      if (i == 2) chk(buf_valid === 1'b0, "R3", buf_valid, 0);
      if (i == 3) chk(buf_valid === 1'b1, "R3", buf_valid, 1);
      if (i == 34) chk(rx_overrun === 1'b0, "R7", rx_overrun, 0);
      if (i == 35) chk(rx_overrun === 1'b1, "R7", rx_overrun, 1);
    end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      for (int j = 0; j < 4; j++) e[j*8 +: 8] = 8'(4 * k + j + 16);
      drain(e, 3'd4, "R3");
    end
    chk(buf_valid === 1'b0, "R3", buf_valid, 0);

    // R5: flush of the three bytes that still fitted, then an empty flush
    flush_only();
    drain(32'h0032_3130, 3'd3, "R5");
    flush_only();
    chk(buf_valid === 1'b0, "R5", buf_valid, 0);

    // R6: byte and flush together
    rx_send(8'hC1, 1'b0);
    rx_send(8'hC2, 1'b0);
    rx_send(8'hC3, 1'b1);
    drain(32'h00C3_C2C1, 3'd3, "R6");
    rx_send(8'hD4, 1'b1);
    drain(32'h0000_00D4, 3'd1, "R6");
    chk(buf_valid === 1'b0, "R6", buf_valid, 0);

    // R7: flag clears while disabled
    chk(rx_overrun === 1'b1, "R7", rx_overrun, 1);
    chan_en = 1'b0; tick();
    chk(rx_overrun === 1'b0, "R7", rx_overrun, 0);
    chan_en = 1'b1; tick();
    set_cfg(1'b0, 1'b1);

    // R4 R7: narrow storage, nine bytes into eight entries
    for (int i = 0; i < 9; i++) begin
      rx_send(8'(8'hA0 + i), 1'b0);
      if (i == 0) chk(buf_valid === 1'b1, "R4", buf_valid, 1);
      if (i == 7) chk(rx_overrun === 1'b0, "R7", rx_overrun, 0);
      if (i == 8) chk(rx_overrun === 1'b1, "R7", rx_overrun, 1);
    end
    for (int k = 0; k < 8; k++) drain(32'(8'hA0 + k), 3'd1, "R4");
    chk(buf_valid === 1'b0, "R4", buf_valid, 0);
    flush_only();
    chk(buf_valid === 1'b0, "R5", buf_valid, 0);

    // R9: taking a new receive mode empties the receive FIFO
    rx_send(8'h77, 1'b0);
    chk(buf_valid === 1'b1, "R9", buf_valid, 1);
    set_cfg(1'b0, 1'b0);
    chk(buf_valid === 1'b0, "R9", buf_valid, 0);
    // R9: it also discards bytes pending in the packer
    rx_send(8'h01, 1'b0);
    rx_send(8'h02, 1'b0);
    set_cfg(1'b0, 1'b1);
    set_cfg(1'b0, 1'b0);
    flush_only();
    chk(buf_valid === 1'b0, "R9", buf_valid, 0);
    rx_send(8'h03, 1'b1);
    drain(32'h0000_0003, 3'd1, "R9");

    finish_run();
  end

endmodule